// File: doc/BRIEF.md
# Burst Write Slave with Delayed Response

This block is the write side of a memory-mapped slave. It takes a burst description on a write-address channel, absorbs the data beats on a write-data channel, stores each beat into a small array of word registers, and then reports the outcome on a write-response channel. All three channels use a valid/ready handshake. A transfer takes place only on a rising clock edge where both valid and ready are high. The master owns valid on the address and data channels, and the slave owns valid on the response channel.

Back-pressure works as follows. The slave raises address ready only when it is idle, so only one write is outstanding at a time. Data ready is high from the cycle after the address is accepted until the final beat is taken, so beats can stream one per cycle. The master may insert idle cycles by lowering data valid. The response is raised two cycles after the final beat's handshake. The slave then holds it, with its code stable, for as long as the master keeps response ready low. Beat addresses follow the burst type: fixed, incrementing or wrapping. A beat whose address falls outside the array is dropped, and the response is then a decode error. The whole array is driven out as a flat bus for neighbouring logic to use.

Top module: `burst_wr_slave`

## Requirements
- R1: After reset, address ready is 1, data ready is 0, response valid is 0 and every stored word is zero.
- R2: Address ready falls after an address handshake and stays low until the response handshake completes. It is 1 again in the cycle after that handshake.
- R3: Once a burst is accepted, data ready stays high until the final beat is taken. Beats can be accepted on consecutive cycles.
- R4: Burst type 2'b01 (incrementing) stores beat i at byte address start + 4·i. Each register word is 4 bytes wide and word k sits at byte address 4·k.
- R5: Burst type 2'b00 (fixed) sends every beat to the start address, so the last beat's data is the value that remains there.
- R6: Burst type 2'b10 (wrapping), with a beat count of 2, 4, 8 or 16, keeps addresses inside a region of beats·4 bytes aligned to its own size. It starts at the start address and wraps to the region base after the region's top word.
- R7: Response valid is low in the cycle right after the final beat's handshake and high in the cycle after that.
- R8: While response ready is low, response valid stays high and the response code stays unchanged.
- R9: The response code is 2'b00 when every beat hit the array. It is 2'b11 when any beat's address is at or beyond 4·NUM_WORDS, and such beats leave all stored words unchanged.
- R10: The address channel's length field holds beats minus one. The burst ends after that many beats, and the master's last flag must be set on exactly that beat.
- R11: A 4-beat incrementing burst with no gaps, whose address is accepted at edge n and whose response ready is held high, completes its response handshake at edge n+6.
- R12: Data offered while no burst is open is not accepted (data ready is 0) and leaves the stored words unchanged. Data ready is also 0 while the response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Address channel valid |
| aw_ready | output | 1 | Address channel ready |
| aw_addr | input | ADDR_W | Burst start byte address |
| aw_len | input | LEN_W | Beats in burst minus one |
| aw_burst | input | 2 | Burst type: 00 fixed, 01 incrementing, 10 wrapping |
| w_valid | input | 1 | Data channel valid |
| w_ready | output | 1 | Data channel ready |
| w_data | input | DATA_W | Beat data (full word) |
| w_last | input | 1 | Marks the final beat of the burst |
| b_valid | output | 1 | Response channel valid |
| b_ready | input | 1 | Response channel ready |
| b_resp | output | 2 | Response code: 00 okay, 11 decode error |
| reg_q | output | NUM_WORDS*DATA_W | Flattened register array, word k in bits [k*DATA_W +: DATA_W] |

## Verification
The assertions assume a well-behaved master. Its last flag must agree with the length field, a wrapping burst must use a beat count of 2, 4, 8 or 16, and start addresses must be word aligned. The stimulus respects these rules by building each burst from its length: the last flag goes on beat `len` only, wrapping lengths are drawn from 1, 3, 7 and 15, and addresses are multiples of four. Random gaps between data beats and random delays on response ready exercise the back-pressure paths. Start addresses are mostly inside the array, with some past its end, so that partial and full decode errors occur.

// File: rtl/bws_pkg.sv
package bws_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10
  } burst_e;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_DECERR = 2'b11
  } resp_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_GAP,
    ST_RESP
  } wr_state_e;
endpackage

// File: rtl/bws_addr_seq.sv
module bws_addr_seq
  import bws_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 8,
  parameter int NUM_WORDS = 16,
  parameter int SEL_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [1:0]        burst,
  input  logic              advance,
  output logic [SEL_W-1:0]  sel,
  output logic              hit
);
  localparam int STEP    = DATA_W / 8;
  localparam int STEP_SH = $clog2(STEP);
  localparam int IDX_W   = ADDR_W - STEP_SH;

  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  burst_e            burst_q;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] nxt;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    span = (ADDR_W'(len_q) + ADDR_W'(1)) << STEP_SH;
    mask = span - ADDR_W'(1);
    inc  = addr_q + ADDR_W'(STEP);
    case (burst_q)
      BURST_FIXED: nxt = addr_q;
      BURST_WRAP:  nxt = (addr_q & ~mask) | (inc & mask);
      default:     nxt = inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      len_q   <= '0;
      burst_q <= BURST_INCR;
    end else if (load) begin
      addr_q  <= start_addr;
      len_q   <= len;
      burst_q <= burst_e'(burst);
    end else if (advance) begin
      addr_q  <= nxt;
    end
  end

  assign idx = addr_q[ADDR_W-1:STEP_SH];
  assign hit = idx < IDX_W'(NUM_WORDS);
  assign sel = idx[SEL_W-1:0];
endmodule

// File: rtl/bws_store.sv
module bws_store #(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 16,
  parameter int SEL_W     = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [SEL_W-1:0]              sel,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NUM_WORDS*DATA_W-1:0]   q
);
  logic [DATA_W-1:0] word_q [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q[g] <= '0;
      end else if (we && sel == SEL_W'(g)) begin
        word_q[g] <= wdata;
      end
    end
    assign q[g*DATA_W +: DATA_W] = word_q[g];
  end
endmodule

// File: rtl/bws_ctrl.sv
module bws_ctrl
  import bws_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aw_valid,
  input  logic [LEN_W-1:0] aw_len,
  input  logic             w_valid,
  input  logic             b_ready,
  input  logic             beat_hit,
  output logic             aw_ready,
  output logic             w_ready,
  output logic             b_valid,
  output logic [1:0]       b_resp,
  output logic             aw_fire,
  output logic             w_fire,
  output logic [LEN_W-1:0] beat_cnt,
  output logic [LEN_W-1:0] cur_len
);
  wr_state_e st_q;
  logic      err_q;
  logic      final_beat;

  assign aw_ready   = (st_q == ST_IDLE);
  assign w_ready    = (st_q == ST_DATA);
  assign b_valid    = (st_q == ST_RESP);
  assign aw_fire    = aw_valid && aw_ready;
  assign w_fire     = w_valid && w_ready;
  assign final_beat = (beat_cnt == cur_len);
  assign b_resp     = err_q ? RESP_DECERR : RESP_OKAY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      err_q    <= 1'b0;
      beat_cnt <= '0;
      cur_len  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (aw_fire) begin
          st_q     <= ST_DATA;
          cur_len  <= aw_len;
          beat_cnt <= '0;
          err_q    <= 1'b0;
        end
        ST_DATA: if (w_fire) begin
          err_q <= err_q | ~beat_hit;
          if (final_beat) st_q <= ST_GAP;
          else beat_cnt <= beat_cnt + LEN_W'(1);
        end
        ST_GAP:  st_q <= ST_RESP;
        ST_RESP: if (b_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_wr_slave.sv
module burst_wr_slave #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 8,
  parameter int NUM_WORDS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        aw_valid,
  output logic                        aw_ready,
  input  logic [ADDR_W-1:0]           aw_addr,
  input  logic [LEN_W-1:0]            aw_len,
  input  logic [1:0]                  aw_burst,
  input  logic                        w_valid,
  output logic                        w_ready,
  input  logic [DATA_W-1:0]           w_data,
  input  logic                        w_last,
  output logic                        b_valid,
  input  logic                        b_ready,
  output logic [1:0]                  b_resp,
  output logic [NUM_WORDS*DATA_W-1:0] reg_q
);
  localparam int SEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic             aw_fire;
  logic             w_fire;
  logic             hit;
  logic [SEL_W-1:0] sel;
  logic [LEN_W-1:0] beat_cnt;
  logic [LEN_W-1:0] cur_len;
  logic             last_unused;

  assign last_unused = w_last;

  bws_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_len(aw_len),
    .w_valid(w_valid), .b_ready(b_ready), .beat_hit(hit),
    .aw_ready(aw_ready), .w_ready(w_ready),
    .b_valid(b_valid), .b_resp(b_resp),
    .aw_fire(aw_fire), .w_fire(w_fire),
    .beat_cnt(beat_cnt), .cur_len(cur_len)
  );

  bws_addr_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .NUM_WORDS(NUM_WORDS), .SEL_W(SEL_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_n),
    .load(aw_fire), .start_addr(aw_addr), .len(aw_len), .burst(aw_burst),
    .advance(w_fire), .sel(sel), .hit(hit)
  );

  bws_store #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .SEL_W(SEL_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(w_fire && hit), .sel(sel), .wdata(w_data), .q(reg_q)
  );
endmodule

// File: rtl/burst_wr_slave_chk.sv
module burst_wr_slave_chk #(
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 8,
  parameter int NUM_WORDS = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        aw_valid,
  input logic                        aw_ready,
  input logic                        w_valid,
  input logic                        w_ready,
  input logic                        w_last,
  input logic                        b_valid,
  input logic                        b_ready,
  input logic [1:0]                  b_resp,
  input logic [NUM_WORDS*DATA_W-1:0] reg_q,
  input logic [LEN_W-1:0]            beat_cnt,
  input logic [LEN_W-1:0]            cur_len
);
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && aw_ready |=> !aw_ready); // R2
  AST_NO_AW_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> !aw_ready); // R2
  AST_WREADY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && w_ready && !w_last |=> w_ready); // R3
  AST_RESP_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && w_ready && w_last |=> !b_valid ##1 b_valid); // R7
  AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid && !b_ready |=> b_valid && $stable(b_resp)); // R8
  AST_RESP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> (b_resp == 2'b00 || b_resp == 2'b11)); // R9
  AST_LAST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && w_ready |-> (w_last == (beat_cnt == cur_len))); // R10
  AST_NO_WREADY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_ready || b_valid) |-> !w_ready); // R12
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_valid && w_ready) |=> $stable(reg_q)); // R12
endmodule

bind burst_wr_slave burst_wr_slave_chk #(
  .DATA_W(DATA_W), .LEN_W(LEN_W), .NUM_WORDS(NUM_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .aw_valid(aw_valid), .aw_ready(aw_ready),
  .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
  .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
  .reg_q(reg_q), .beat_cnt(beat_cnt), .cur_len(cur_len)
);

// File: tb/burst_wr_slave_tb.sv
module burst_wr_slave_tb;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int LEN_W     = 8;
  localparam int NUM_WORDS = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                        rst_n;
  logic                        aw_valid, aw_ready;
  logic [ADDR_W-1:0]           aw_addr;
  logic [LEN_W-1:0]            aw_len;
  logic [1:0]                  aw_burst;
  logic                        w_valid, w_ready, w_last;
  logic [DATA_W-1:0]           w_data;
  logic                        b_valid, b_ready;
  logic [1:0]                  b_resp;
  logic [NUM_WORDS*DATA_W-1:0] reg_q;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [DATA_W-1:0] model [NUM_WORDS];

  burst_wr_slave #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .NUM_WORDS(NUM_WORDS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
    .aw_len(aw_len), .aw_burst(aw_burst),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
    .reg_q(reg_q)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int beat_addr(int s, int len, int bt, int i);
    int span, base;
    if (bt == 0) return s;
    if (bt == 2) begin
      span = (len + 1) * 4;
      base = (s / span) * span;
      return base + ((s - base) + i * 4) % span;
    end
    return s + 4 * i;
  endfunction

  task automatic chk_regs(string req);
    for (int k = 0; k < NUM_WORDS; k++)
      chk(req, 64'(reg_q[k*DATA_W +: DATA_W]), 64'(model[k]));
  endtask

  task automatic do_write(int a, int len, int bt, int gapmax, int bdly, bit tim);
    int  aw_edge, last_edge, ad;
    bit  hs;
    bit  any_err = 1'b0;
    logic [1:0] r0;
    string req;
    req = (bt == 0) ? "R5 fixed storage" : (bt == 2) ? "R6 wrap storage" : "R4 incr storage";
    @(negedge clk);
    aw_valid = 1'b1; aw_addr = ADDR_W'(a); aw_len = LEN_W'(len); aw_burst = 2'(bt);
    forever begin
      hs = aw_ready;
      @(posedge clk);
      if (hs) break;
      @(negedge clk);
    end
    @(negedge clk);
    aw_edge = cyc;
    aw_valid = 1'b0;
    chk("R2 address ready low after accept", 64'(aw_ready), 64'd0);
    for (int i = 0; i <= len; i++) begin
      int g;
      g = (gapmax > 0) ? int'($urandom_range(gapmax, 0)) : 0;
      repeat (g) @(negedge clk);
      w_valid = 1'b1; w_data = $urandom; w_last = (i == len);
      forever begin
        hs = w_ready;
        @(posedge clk);
        if (hs) break;
        @(negedge clk);
      end
      @(negedge clk);
      ad = beat_addr(a, len, bt, i);
      if (ad < NUM_WORDS * 4) model[ad / 4] = w_data;
      else any_err = 1'b1;
      if (i == len) last_edge = cyc;
      w_valid = 1'b0; w_last = 1'b0;
      if (i != len && g == 0) chk("R3 data ready held mid-burst", 64'(w_ready), 64'd1);
    end
    chk("R7 response low one cycle after last beat", 64'(b_valid), 64'd0);
    @(negedge clk);
    chk("R7 response high two cycles after last beat", 64'(b_valid), 64'd1);
    chk("R9 response code", 64'(b_resp), any_err ? 64'h3 : 64'h0);
    r0 = b_resp;
    repeat (bdly) begin
      @(negedge clk);
      chk("R8 response valid held", 64'(b_valid), 64'd1);
      chk("R8 response code stable", 64'(b_resp), 64'(r0));
      chk("R12 data ready low while response pending", 64'(w_ready), 64'd0);
      chk("R2 address ready low while response pending", 64'(aw_ready), 64'd0);
    end
    b_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    b_ready = 1'b0;
    if (tim) chk("R11 response handshake edge offset", 64'(cyc - aw_edge), 64'd6);
    chk("R2 address ready back after response", 64'(aw_ready), 64'd1);
    chk("R8 response valid dropped after handshake", 64'(b_valid), 64'd0);
    chk_regs(any_err ? "R9 storage after decode error" : req);
  endtask

  initial begin
    wait (cyc == 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion earlier", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < NUM_WORDS; k++) model[k] = '0;
    rst_n = 1'b0; aw_valid = 1'b0; aw_addr = '0; aw_len = '0; aw_burst = '0;
    w_valid = 1'b0; w_data = '0; w_last = 1'b0; b_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset address ready", 64'(aw_ready), 64'd1);
    chk("R1 reset data ready", 64'(w_ready), 64'd0);
    chk("R1 reset response valid", 64'(b_valid), 64'd0);
    chk_regs("R1 reset storage");

    // R12: data offered with no burst open
    w_valid = 1'b1; w_data = 32'hDEAD_BEEF; w_last = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R12 data ready low while idle", 64'(w_ready), 64'd0);
    end
    w_valid = 1'b0; w_last = 1'b0;
    @(negedge clk);
    chk_regs("R12 idle data ignored");

    // R11 reference: 4-beat incrementing burst, no gaps, response ready at once
    do_write(32'h10, 3, 1, 0, 0, 1'b1);
    // R5 fixed burst
    do_write(32'h08, 3, 0, 0, 2, 1'b0);
    // R6 wrap from mid-region: 0x08,0x0C,0x00,0x04
    do_write(32'h08, 3, 2, 0, 1, 1'b0);
    // R6 eight-beat wrap starting at 0x34
    do_write(32'h34, 7, 2, 1, 0, 1'b0);
    // R9 burst running past the array end
    do_write(32'h3C, 2, 1, 0, 3, 1'b0);
    // R9 single beat entirely out of range
    do_write(32'h100, 0, 1, 0, 0, 1'b0);
    // R10 single-beat burst
    do_write(32'h00, 0, 1, 0, 0, 1'b0);

    for (int t = 0; t < 40; t++) begin
      int bt, len, a;
      bt = int'($urandom_range(2, 0));
      if (bt == 2) len = (2 << $urandom_range(3, 0)) - 1;
      else len = int'($urandom_range(15, 0));
      if ($urandom_range(4, 0) == 0) a = 4 * int'($urandom_range(40, 16));
      else a = 4 * int'($urandom_range(NUM_WORDS - 1, 0));
      do_write(a, len, bt, 2, int'($urandom_range(3, 0)), 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule